// File: doc/BRIEF.md
# Daisy-Chain Serial Write Master

This block is the host-side controller for a string of identical 16-bit serial receivers. Each receiver's data output feeds the next receiver's data input. To change the word held by one receiver, the whole chain has to be shifted in a single chip-select window. The block accepts a device index and a 16-bit word on a one-cycle start pulse. It assembles a frame of `NUM_DEV`×16 bits. In that frame the addressed receiver's slot carries the word and every other slot carries the all-zero no-operation word. The block then drives chip select, serial clock and data from a system-clock divider and raises a one-cycle done pulse when it has finished.

Receivers shift on the falling serial clock edge. The master therefore changes data only when it raises the clock, and each clock phase lasts `HALF_CYC` system cycles. Chip-select lead, trailing hold and the inter-frame gap are built from that same phase length. Choose `HALF_CYC` so that one phase is at least 33 ns. The default of 9 cycles is meant for a 250 MHz system clock and gives about 13.9 MHz on the serial clock.

The last receiver's output can optionally be routed back to the block. The bits that come back during a frame must equal the previous frame, because the chain delays everything by exactly one frame. When the `CHECK_EN` parameter is set, the block compares the returned bits against the previous frame and reports any difference.

Top module: `dcw_chain_master`

## Requirements
- R1: After reset the block shows the idle state: `cs_n_o`=1, `sclk_o`=0, `mosi_o`=0, and `busy_o`, `done_o` and `mismatch_o` all 0.
- R2: Each frame has exactly `NUM_DEV`×16 falling serial clock edges while `cs_n_o` is low, followed by a single rising edge of `cs_n_o`.
- R3: Device index 0 is the receiver whose input is `mosi_o`, and index `NUM_DEV-1` is the farthest receiver. Slots go out farthest first, so after the frame receiver i holds slot i. Each 16-bit word is sent MSB first.
- R4: Every slot other than the addressed one carries the no-operation word 16'h0000, whose top four control bits are 0000.
- R5: `sclk_o` is low whenever `cs_n_o` is high. While `cs_n_o` is low, `mosi_o` changes only in the cycle where `sclk_o` rises, so it is steady across every falling edge.
- R6: Every high phase and every low phase of `sclk_o` lasts `HALF_CYC` system cycles. The first falling edge comes 2×`HALF_CYC` cycles after `cs_n_o` falls. `cs_n_o` rises `HALF_CYC` cycles after the last falling edge. `done_o` follows `HALF_CYC` cycles after `cs_n_o` rises.
- R7: `busy_o` rises in the cycle after an accepted start. `done_o` is a one-cycle pulse in the first cycle that `busy_o` is low again.
- R8: A start pulse while `busy_o` is high is ignored. The current frame completes unchanged and no second frame follows.
- R9: A device index of `NUM_DEV` or more produces a frame made entirely of no-operation words.
- R10: With `CHECK_EN` set, `miso_i` is sampled at every rising serial clock edge. When `done_o` pulses, `mismatch_o` is 1 exactly when those bits differ from the previous frame, taken as all zeros before the first frame. `mismatch_o` holds until the next done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to write a frame |
| dev_idx_i | input | $clog2(NUM_DEV+1) | Target receiver index, sampled with start |
| word_i | input | 16 | Word for the target receiver, sampled with start |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cs_n_o | output | 1 | Chain chip select, active low |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data to receiver 0 |
| miso_i | input | 1 | Serial data returned from the last receiver |
| mismatch_o | output | 1 | Returned bits differed from the previous frame |

## Verification
The bench builds the block with three receivers, a phase length of two system cycles and the return check enabled. A behavioural model of three chained receivers sits on the serial lines. Three devices is enough to see a slot at each end of the frame and one in the middle. It also leaves one index code unused, which exercises the all-no-operation frame. The short phase keeps each 48-bit frame to about two hundred cycles while still separating lead, high, low, tail and gap lengths by exact cycle counts. The bench corrupts the return line for one frame to provoke a mismatch.

// File: rtl/dcw_pkg.sv
package dcw_pkg;

    localparam int WORD_W = 16;
    localparam logic [WORD_W-1:0] NOP_WORD = 16'h0000;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD,
        PH_HIGH,
        PH_LOW,
        PH_TAIL,
        PH_GAP
    } phase_e;

endpackage

// File: rtl/dcw_frame_build.sv
module dcw_frame_build #(
    parameter int NUM_DEV = 4,
    parameter int IDX_W   = 3
) (
    input  logic [IDX_W-1:0]                    dev_idx_i,
    input  logic [dcw_pkg::WORD_W-1:0]          word_i,
    output logic [NUM_DEV*dcw_pkg::WORD_W-1:0]  frame_o
);
    import dcw_pkg::*;

    // Slot g sits at bits [g*16 +: 16]; the top slot leaves the master first,
    // so it ends up in the farthest receiver.
    for (genvar g = 0; g < NUM_DEV; g++) begin : g_slot
        logic hit;
        assign hit = (dev_idx_i == IDX_W'(g));
        assign frame_o[g*WORD_W +: WORD_W] = hit ? word_i : NOP_WORD;
    end

endmodule

// File: rtl/dcw_phase_timer.sv
module dcw_phase_timer #(
    parameter int HALF_CYC = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expire_o
);
    localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HALF_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    assign expire_o = (tmr_q.cnt == '0);

    always_comb begin
        tmr_d = tmr_q;
        if (load_i || expire_o) begin
            tmr_d.cnt = RELOAD;
        end else begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '{cnt: RELOAD};
        end else begin
            tmr_q <= tmr_d;
        end
    end

    // R6: the count never exceeds the reload value
    assert_timer_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.cnt <= RELOAD);

endmodule

// File: rtl/dcw_rx_check.sv
module dcw_rx_check #(
    parameter int TOTAL = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic [TOTAL-1:0] frame_i,
    input  logic             sample_i,
    input  logic             bit_i,
    input  logic             finish_i,
    output logic             mismatch_o
);
    typedef struct packed {
        logic [TOTAL-1:0] prev;
        logic [TOTAL-1:0] cur;
        logic [TOTAL-1:0] rx;
        logic             mism;
    } rx_t;

    rx_t rx_d, rx_q;

    assign mismatch_o = rx_q.mism;

    always_comb begin
        rx_d = rx_q;
        if (arm_i) begin
            rx_d.cur = frame_i;
            rx_d.rx  = '0;
        end
        if (sample_i) begin
            rx_d.rx = {rx_q.rx[TOTAL-2:0], bit_i};
        end
        if (finish_i) begin
            rx_d.mism = (rx_q.rx != rx_q.prev);
            rx_d.prev = rx_q.cur;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else begin
            rx_q <= rx_d;
        end
    end

    // R10: the flag only moves when a frame finishes
    assert_mismatch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !finish_i |=> $stable(mismatch_o));

endmodule

// File: rtl/dcw_chain_master.sv
module dcw_chain_master #(
    parameter int NUM_DEV  = 4,
    parameter int HALF_CYC = 9,
    parameter bit CHECK_EN = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic [$clog2(NUM_DEV+1)-1:0]  dev_idx_i,
    input  logic [15:0]                   word_i,
    output logic                          busy_o,
    output logic                          done_o,
    output logic                          cs_n_o,
    output logic                          sclk_o,
    output logic                          mosi_o,
    input  logic                          miso_i,
    output logic                          mismatch_o
);
    import dcw_pkg::*;

    localparam int IDX_W  = $clog2(NUM_DEV + 1);
    localparam int TOTAL  = NUM_DEV * WORD_W;
    localparam int BCNT_W = $clog2(TOTAL + 1);
    localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(TOTAL);

    typedef struct packed {
        phase_e            phase;
        logic [TOTAL-1:0]  sh;
        logic [BCNT_W-1:0] sent;
        logic              cs_n;
        logic              sclk;
        logic              mosi;
        logic              done;
    } mst_t;

    mst_t st_d, st_q;

    logic [TOTAL-1:0] frame;
    logic             expire;
    logic             accept;
    logic             rise;
    logic             finish;

    dcw_frame_build #(
        .NUM_DEV (NUM_DEV),
        .IDX_W   (IDX_W)
    ) u_frame (
        .dev_idx_i (dev_idx_i),
        .word_i    (word_i),
        .frame_o   (frame)
    );

    dcw_phase_timer #(
        .HALF_CYC (HALF_CYC)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (accept),
        .expire_o (expire)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        accept    = 1'b0;
        rise      = 1'b0;
        finish    = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    accept     = 1'b1;
                    st_d.phase = PH_LEAD;
                    st_d.sh    = frame;
                    st_d.sent  = '0;
                    st_d.cs_n  = 1'b0;
                end
            end
            PH_LEAD, PH_LOW: begin
                if (expire) begin
                    rise       = 1'b1;
                    st_d.phase = PH_HIGH;
                    st_d.sclk  = 1'b1;
                    st_d.mosi  = st_q.sh[TOTAL-1];
                    st_d.sh    = {st_q.sh[TOTAL-2:0], 1'b0};
                    st_d.sent  = st_q.sent + 1'b1;
                end
            end
            PH_HIGH: begin
                if (expire) begin
                    st_d.sclk  = 1'b0;
                    st_d.phase = (st_q.sent == LAST_BIT) ? PH_TAIL : PH_LOW;
                end
            end
            PH_TAIL: begin
                if (expire) begin
                    st_d.cs_n  = 1'b1;
                    st_d.mosi  = 1'b0;
                    st_d.phase = PH_GAP;
                end
            end
            PH_GAP: begin
                if (expire) begin
                    finish     = 1'b1;
                    st_d.done  = 1'b1;
                    st_d.phase = PH_IDLE;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, sh: '0, sent: '0, cs_n: 1'b1,
                      sclk: 1'b0, mosi: 1'b0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = (st_q.phase != PH_IDLE);
    assign done_o = st_q.done;
    assign cs_n_o = st_q.cs_n;
    assign sclk_o = st_q.sclk;
    assign mosi_o = st_q.mosi;

    if (CHECK_EN) begin : g_rx
        dcw_rx_check #(
            .TOTAL (TOTAL)
        ) u_rx (
            .clk        (clk),
            .rst_n      (rst_n),
            .arm_i      (accept),
            .frame_i    (frame),
            .sample_i   (rise),
            .bit_i      (miso_i),
            .finish_i   (finish),
            .mismatch_o (mismatch_o)
        );
    end else begin : g_no_rx
        assign mismatch_o = 1'b0;
    end

    // Checker state: falling edges counted inside the chip-select window
    logic              sclk_prev;
    logic [BCNT_W-1:0] fall_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            fall_cnt  <= '0;
        end else begin
            sclk_prev <= sclk_o;
            if (cs_n_o) begin
                fall_cnt <= '0;
            end else if (sclk_prev && !sclk_o) begin
                fall_cnt <= fall_cnt + 1'b1;
            end
        end
    end

    assert_frame_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |-> (fall_cnt == LAST_BIT));

    assert_sclk_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);

    assert_mosi_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk_o) |-> $stable(mosi_o));

    assert_done_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o) && cs_n_o));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: tb/tb_dcw_chain_master.sv
`timescale 1ns/1ps
module tb_dcw_chain_master;

    localparam int TB_DEV  = 3;
    localparam int TB_HALF = 2;
    localparam int TOTAL   = TB_DEV * 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  idx = '0;
    logic [15:0] word = '0;
    logic        busy, done, cs_n, sclk, mosi, miso, mismatch;
    logic        inject = 1'b0;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dcw_chain_master #(
        .NUM_DEV  (TB_DEV),
        .HALF_CYC (TB_HALF),
        .CHECK_EN (1'b1)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .dev_idx_i  (idx),
        .word_i     (word),
        .busy_o     (busy),
        .done_o     (done),
        .cs_n_o     (cs_n),
        .sclk_o     (sclk),
        .mosi_o     (mosi),
        .miso_i     (miso),
        .mismatch_o (mismatch)
    );

    // Behavioural receiver chain: shift on falling sclk, act on cs rise
    logic [15:0]       dsr  [TB_DEV];
    logic [15:0]       dlat [TB_DEV];
    logic [TB_DEV-1:0] din_v;

    always_comb begin
        din_v[0] = mosi;
        for (int i = 1; i < TB_DEV; i++) din_v[i] = dsr[i-1][15];
    end

    assign miso = dsr[TB_DEV-1][15] ^ inject;

    initial begin
        for (int i = 0; i < TB_DEV; i++) begin
            dsr[i]  = '0;
            dlat[i] = '0;
        end
    end

    always @(negedge sclk) begin
        if (!cs_n) begin
            for (int i = 0; i < TB_DEV; i++) dsr[i] <= {dsr[i][14:0], din_v[i]};
        end
    end

    always @(posedge cs_n) begin
        for (int i = 0; i < TB_DEV; i++) dlat[i] <= dsr[i];
    end

    // Timing monitor, sampled on the falling system clock
    int  ncyc = 0;
    int  t_cs_fall, t_first_fall, t_last_fall, t_cs_rise, t_done;
    int  falls = 0, hi_run = 0, lo_run = 0, hi_bad = 0, lo_bad = 0, mosi_bad = 0;
    int  done_cnt = 0, idle_clk_bad = 0;
    logic prev_cs = 1'b1, prev_sclk = 1'b0, prev_mosi = 1'b0;

    always @(negedge clk) begin
        ncyc++;
        if (rst_n) begin
            if (prev_cs && !cs_n) begin
                t_cs_fall = ncyc;
                falls = 0;
            end
            if (prev_sclk && !sclk) begin
                if (falls == 0) t_first_fall = ncyc;
                t_last_fall = ncyc;
                falls++;
                if (hi_run != TB_HALF) hi_bad++;
            end
            if (!prev_sclk && sclk && falls > 0 && lo_run != TB_HALF) lo_bad++;
            if (!cs_n && (mosi != prev_mosi) && !(!prev_sclk && sclk)) mosi_bad++;
            if (cs_n && sclk) idle_clk_bad++;
            if (!prev_cs && cs_n) t_cs_rise = ncyc;
            if (done) begin
                t_done = ncyc;
                done_cnt++;
            end
            hi_run = sclk ? (prev_sclk ? hi_run + 1 : 1) : 0;
            lo_run = (!sclk && !cs_n) ? (prev_sclk ? 1 : lo_run + 1) : 0;
        end
        prev_cs   = cs_n;
        prev_sclk = sclk;
        prev_mosi = mosi;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_latched(input string req, input logic [15:0] e0,
                                 input logic [15:0] e1, input logic [15:0] e2);
        check(dlat[0] == e0, req, 64'(dlat[0]), 64'(e0));
        check(dlat[1] == e1, req, 64'(dlat[1]), 64'(e1));
        check(dlat[2] == e2, req, 64'(dlat[2]), 64'(e2));
    endtask

    // Runs one frame; returns the mismatch flag seen with done
    task automatic run_frame(input logic [1:0] i, input logic [15:0] w,
                             input bit corrupt, output logic mism);
        @(negedge clk);
        start = 1'b1;
        idx   = i;
        word  = w;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R7 busy after start", 64'(busy), 64'd1);
        inject = corrupt;
        while (!done) @(negedge clk);
        mism = mismatch;
        check(busy == 1'b0, "R7 busy low at done", 64'(busy), 64'd0);
        inject = 1'b0;
        @(negedge clk);
        check(done == 1'b0, "R7 done single cycle", 64'(done), 64'd0);
    endtask

    task automatic test_reset();
        check(cs_n == 1'b1, "R1 cs_n", 64'(cs_n), 64'd1);
        check(sclk == 1'b0, "R1 sclk", 64'(sclk), 64'd0);
        check(mosi == 1'b0, "R1 mosi", 64'(mosi), 64'd0);
        check({busy, done, mismatch} == 3'b000, "R1 busy/done/mismatch",
              64'({busy, done, mismatch}), 64'd0);
    endtask

    task automatic test_near_device();
        logic m;
        run_frame(2'd0, 16'hA5C3, 1'b0, m);
        check_latched("R3 R4 nearest target", 16'hA5C3, 16'h0000, 16'h0000);
        check(m == 1'b0, "R10 first frame returns zeros", 64'(m), 64'd0);
        check(falls == TOTAL, "R2 falling edge count", 64'(falls), 64'(TOTAL));
    endtask

    task automatic test_far_device_timing();
        logic m;
        run_frame(2'd2, 16'h1234, 1'b0, m);
        check_latched("R3 R4 farthest target", 16'h0000, 16'h0000, 16'h1234);
        check(m == 1'b0, "R10 clean return", 64'(m), 64'd0);
        check(t_first_fall - t_cs_fall == 2 * TB_HALF, "R6 lead",
              64'(t_first_fall - t_cs_fall), 64'(2 * TB_HALF));
        check(t_cs_rise - t_last_fall == TB_HALF, "R6 tail",
              64'(t_cs_rise - t_last_fall), 64'(TB_HALF));
        check(t_done - t_cs_rise == TB_HALF, "R6 gap to done",
              64'(t_done - t_cs_rise), 64'(TB_HALF));
        check(hi_bad == 0, "R6 high phase length", 64'(hi_bad), 64'd0);
        check(lo_bad == 0, "R6 low phase length", 64'(lo_bad), 64'd0);
        check(mosi_bad == 0, "R5 data moves only at rising edge", 64'(mosi_bad), 64'd0);
        check(idle_clk_bad == 0, "R5 clock low while deselected", 64'(idle_clk_bad), 64'd0);
    endtask

    task automatic test_mismatch();
        logic m;
        run_frame(2'd1, 16'hBEEF, 1'b1, m);
        check_latched("R3 middle target", 16'h0000, 16'hBEEF, 16'h0000);
        check(m == 1'b1, "R10 corrupted return flagged", 64'(m), 64'd1);
        repeat (5) @(negedge clk);
        check(mismatch == 1'b1, "R10 flag held", 64'(mismatch), 64'd1);
        run_frame(2'd0, 16'h0F0F, 1'b0, m);
        check(m == 1'b0, "R10 flag clears on clean frame", 64'(m), 64'd0);
        check_latched("R4 idle slots", 16'h0F0F, 16'h0000, 16'h0000);
    endtask

    task automatic test_out_of_range();
        logic m;
        run_frame(2'd3, 16'hFFFF, 1'b0, m);
        check_latched("R9 all no-op frame", 16'h0000, 16'h0000, 16'h0000);
        check(falls == TOTAL, "R2 edge count on no-op frame", 64'(falls), 64'(TOTAL));
    endtask

    task automatic test_start_while_busy();
        int d0;
        d0 = done_cnt;
        @(negedge clk);
        start = 1'b1;
        idx   = 2'd0;
        word  = 16'h1111;
        @(negedge clk);
        start = 1'b0;
        repeat (12) @(negedge clk);
        start = 1'b1;
        idx   = 2'd2;
        word  = 16'hFFFF;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        repeat (30) @(negedge clk);
        check_latched("R8 late start ignored", 16'h1111, 16'h0000, 16'h0000);
        check(done_cnt - d0 == 1, "R8 single done", 64'(done_cnt - d0), 64'd1);
        check(busy == 1'b0 && cs_n == 1'b1, "R8 no second frame",
              64'({busy, cs_n}), 64'b01);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        test_near_device();
        test_far_device_timing();
        test_mismatch();
        test_out_of_range();
        test_start_while_busy();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule